// File: doc/BRIEF.md
# Indexed RGB Palette Lookup Table

This block is a colour lookup table with 256 entries. Each entry holds red, green and blue components of 6 bits. It has two sides. The first is a byte-wide host port with four addressable registers. The second is a video-side port that turns an 8-bit pixel index into a colour triplet.

The host loads entries by writing a start index and then a stream of bytes to the data register. The bytes arrive as red, green and blue in turn. A phase counter tracks which component comes next, and the index moves on by itself after each blue byte. Read-back works the same way through the same data register, but it starts from a separate read index. A mask register is ANDed with every pixel index before the lookup. Its all-ones value leaves the pixel index unchanged.

Top module: `palette_lut`

## Requirements
- R1: While reset is held, all of the following hold. The write index and the read index are 0. The pixel mask is 0xFF. The pixel outputs are 0. The phase counter is at the red position.
- R2: A host write with hostSel=0 loads the write index and returns the phase to red. A host read with hostSel=0 returns the current write index.
- R3: Data-register accesses (hostSel=1) step through red, green and blue. The red and green bytes are only held. The triplet reaches the table when the blue byte is written, and the write index then advances by one.
- R4: Only data bits 5:0 of each component are stored. Data-register reads return bits 7:6 as zero.
- R5: The write index wraps from 255 to 0. After 256 triplets written from index 0, it reads back as 0.
- R6: A host write with hostSel=2 loads the read index and returns the phase to red. Later data-register reads return red, green and blue of that entry in turn. The read index advances after blue and wraps from 255 to 0. A read with hostSel=2 returns the read index.
- R7: A host write with hostSel=3 loads the pixel mask, and a read with hostSel=3 returns it. The lookup uses (pixIdx AND mask). A mask of 0xFF selects pixIdx unchanged.
- R8: The pixel outputs show the entry for the pixIdx sampled at the previous rising clock edge: the latency is one registered cycle.
- R9: A blue-byte write and a lookup can target the same entry in the same cycle. In that case the host write takes priority, and the pixel outputs show the newly written triplet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 2 | Register select: 0 write index, 1 data, 2 read index, 3 pixel mask |
| hostWr | input | 1 | Host write strobe, one access per cycle |
| hostRd | input | 1 | Host read strobe; ignored when hostWr is also high |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Selected register contents, combinational from current state |
| pixIdx | input | 8 | Video-side pixel index |
| pixRed | output | 6 | Red component, registered |
| pixGreen | output | 6 | Green component, registered |
| pixBlue | output | 6 | Blue component, registered |

## Verification
The properties assume that the host raises at most one of its strobes per cycle. They also assume that hostSel, hostWrData and pixIdx change only once between clock edges, and that no input toggles during reset other than reset itself. The bench drives every input one time unit after the rising edge and keeps hostWr and hostRd exclusive. It keeps hostWr low while reset is active and holds pixIdx steady across each sampled edge. This keeps each host transaction aligned to exactly one clock edge, which is the alignment the phase-stepping and hold properties rely on.

// File: rtl/palette_pkg.sv
package palette_pkg;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    SEL_WRIDX = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_RDIDX = 2'd2,
    SEL_MASK  = 2'd3
  } hostSel_t;

  typedef struct packed {
    logic holdRed;
    logic holdGreen;
    logic commit;
  } wrStrobes_t;

endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int HOST_W = 8,
  parameter int COMP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [HOST_W-1:0] hostWrData,
  input  logic [COMP_W-1:0] readComp,
  output wrStrobes_t        strobes,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [IDX_W-1:0]  rdAddr,
  output phase_t            phase,
  output logic [IDX_W-1:0]  pixMask,
  output logic [HOST_W-1:0] hostRdData
);

  hostSel_t sel;
  logic     dataWr;
  logic     dataRd;
  logic     wrIdxLoad;
  logic     rdIdxLoad;
  logic     maskLoad;
  logic     lastPhase;

  assign sel       = hostSel_t'(hostSel);
  assign dataWr    = hostWr && (sel == SEL_DATA);
  // a write in the same cycle wins over a read
  assign dataRd    = hostRd && !hostWr && (sel == SEL_DATA);
  assign wrIdxLoad = hostWr && (sel == SEL_WRIDX);
  assign rdIdxLoad = hostWr && (sel == SEL_RDIDX);
  assign maskLoad  = hostWr && (sel == SEL_MASK);
  assign lastPhase = (phase == PH_BLUE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_RED;
    end else if (wrIdxLoad || rdIdxLoad) begin
      phase <= PH_RED;
    end else if (dataWr || dataRd) begin
      phase <= lastPhase ? PH_RED : phase_t'(phase + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
    end else if (wrIdxLoad) begin
      wrAddr <= hostWrData[IDX_W-1:0];
    end else if (dataWr && lastPhase) begin
      wrAddr <= wrAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
    end else if (rdIdxLoad) begin
      rdAddr <= hostWrData[IDX_W-1:0];
    end else if (dataRd && lastPhase) begin
      rdAddr <= rdAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixMask <= '1;
    end else if (maskLoad) begin
      pixMask <= hostWrData[IDX_W-1:0];
    end
  end

  always_comb begin
    strobes.holdRed   = dataWr && (phase == PH_RED);
    strobes.holdGreen = dataWr && (phase == PH_GREEN);
    strobes.commit    = dataWr && lastPhase;
  end

  always_comb begin
    unique case (sel)
      SEL_WRIDX: hostRdData = HOST_W'(wrAddr);
      SEL_DATA:  hostRdData = HOST_W'(readComp);
      SEL_RDIDX: hostRdData = HOST_W'(rdAddr);
      default:   hostRdData = HOST_W'(pixMask);
    endcase
  end

endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strobes,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [IDX_W-1:0]  rdAddr,
  input  phase_t            phase,
  input  logic [COMP_W-1:0] wrByte,
  input  logic [IDX_W-1:0]  pixIdx,
  input  logic [IDX_W-1:0]  pixMask,
  output logic [COMP_W-1:0] readComp,
  output logic [COMP_W-1:0] pixRed,
  output logic [COMP_W-1:0] pixGreen,
  output logic [COMP_W-1:0] pixBlue
);

  localparam int DEPTH   = 1 << IDX_W;
  localparam int N_COMP  = 3;
  localparam int ENTRY_W = N_COMP * COMP_W;

  logic [ENTRY_W-1:0] table_q [DEPTH];
  logic [COMP_W-1:0]  holdRed;
  logic [COMP_W-1:0]  holdGreen;
  logic [ENTRY_W-1:0] newEntry;
  logic [ENTRY_W-1:0] readEntry;
  logic [ENTRY_W-1:0] pixEntry;
  logic [ENTRY_W-1:0] pixNext;
  logic [IDX_W-1:0]   lookupAddr;
  logic [COMP_W-1:0]  readSlice [N_COMP];
  logic [COMP_W-1:0]  pixSlice  [N_COMP];

  assign newEntry = {holdRed, holdGreen, wrByte};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdRed   <= '0;
      holdGreen <= '0;
    end else begin
      if (strobes.holdRed)   holdRed   <= wrByte;
      if (strobes.holdGreen) holdGreen <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) table_q[wrAddr] <= newEntry;
  end

  // host read-back path
  assign readEntry = table_q[rdAddr];

  // video lookup, with host write forwarded on a same-entry collision
  assign lookupAddr = pixIdx & pixMask;
  assign pixNext    = (strobes.commit && (wrAddr == lookupAddr)) ? newEntry
                                                                 : table_q[lookupAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixEntry <= '0;
    else       pixEntry <= pixNext;
  end

  // component slices: index 0 is red (top bits), 2 is blue
  for (genvar c = 0; c < N_COMP; c++) begin : g_slice
    assign readSlice[c] = readEntry[ENTRY_W-1-c*COMP_W -: COMP_W];
    assign pixSlice[c]  = pixEntry[ENTRY_W-1-c*COMP_W -: COMP_W];
  end

  always_comb begin
    unique case (phase)
      PH_RED:   readComp = readSlice[0];
      PH_GREEN: readComp = readSlice[1];
      default:  readComp = readSlice[2];
    endcase
  end

  assign pixRed   = pixSlice[0];
  assign pixGreen = pixSlice[1];
  assign pixBlue  = pixSlice[2];

endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int HOST_W = 8,
  parameter int COMP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [HOST_W-1:0] hostRdData,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [COMP_W-1:0] pixRed,
  output logic [COMP_W-1:0] pixGreen,
  output logic [COMP_W-1:0] pixBlue
);

  wrStrobes_t        strobes;
  logic [IDX_W-1:0]  wrAddr;
  logic [IDX_W-1:0]  rdAddr;
  logic [IDX_W-1:0]  pixMask;
  logic [COMP_W-1:0] readComp;
  phase_t            phase;

  palette_ctrl #(.IDX_W(IDX_W), .HOST_W(HOST_W), .COMP_W(COMP_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostWrData (hostWrData),
    .readComp   (readComp),
    .strobes    (strobes),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .phase      (phase),
    .pixMask    (pixMask),
    .hostRdData (hostRdData)
  );

  palette_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .phase    (phase),
    .wrByte   (hostWrData[COMP_W-1:0]),
    .pixIdx   (pixIdx),
    .pixMask  (pixMask),
    .readComp (readComp),
    .pixRed   (pixRed),
    .pixGreen (pixGreen),
    .pixBlue  (pixBlue)
  );

endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int IDX_W  = 8,
  parameter int HOST_W = 8,
  parameter int COMP_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        hostSel,
  input logic              hostWr,
  input logic              hostRd,
  input logic [HOST_W-1:0] hostWrData,
  input logic [HOST_W-1:0] hostRdData,
  input logic [IDX_W-1:0]  pixIdx,
  input logic [COMP_W-1:0] pixRed,
  input logic [COMP_W-1:0] pixGreen,
  input logic [COMP_W-1:0] pixBlue
);

  // R1
  reset_outputs_chk: assert property (@(posedge clk)
    !rstN |=> (pixRed == '0 && pixGreen == '0 && pixBlue == '0));

  // R2
  wridx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel == 2'd0) |=>
      (hostSel != 2'd0 || hostRdData == HOST_W'($past(hostWrData[IDX_W-1:0]))));

  // R4
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel == 2'd1) |-> (hostRdData[HOST_W-1:COMP_W] == '0));

  // R7
  mask_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel == 2'd3) |=>
      (hostSel != 2'd3 || hostRdData == HOST_W'($past(hostWrData[IDX_W-1:0]))));

  // R8
  pixel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWr && $past(!hostWr) && $past(rstN) && $stable(pixIdx)) |=>
      ($stable(pixRed) && $stable(pixGreen) && $stable(pixBlue)));

endmodule

bind palette_lut palette_lut_chk #(.IDX_W(IDX_W), .HOST_W(HOST_W), .COMP_W(COMP_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostSel    (hostSel),
  .hostWr     (hostWr),
  .hostRd     (hostRd),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .pixIdx     (pixIdx),
  .pixRed     (pixRed),
  .pixGreen   (pixGreen),
  .pixBlue    (pixBlue)
);

// File: tb/palette_lut_bench.sv
module palette_lut_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostWrData = 8'd0;
  logic [7:0] hostRdData;
  logic [7:0] pixIdx = 8'd0;
  logic [5:0] pixRed, pixGreen, pixBlue;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  palette_lut u_palette_lut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .pixIdx(pixIdx),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue)
  );

  function automatic logic [5:0] comp(input int idx, input int k);
    return 6'((idx + k) & 63);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected host-read bytes from the scoreboard
  always @(negedge clk) begin
    if (hostRd && rstN) begin
      if (expQ.size() == 0) begin
        chk("queue", 8'hxx, 8'h00);
      end else begin
        chk(tagQ.pop_front(), hostRdData, expQ.pop_front());
      end
    end
  end

  task automatic hostWrite(input logic [1:0] s, input logic [7:0] d);
    hostSel = s; hostWrData = d; hostWr = 1'b1;
    @(posedge clk); #1;
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] s, input logic [7:0] exp, input string req);
    expQ.push_back(exp); tagQ.push_back(req);
    hostSel = s; hostRd = 1'b1;
    @(posedge clk); #1;
    hostRd = 1'b0;
  endtask

  task automatic pixCheck(input logic [7:0] idx, input logic [5:0] r, input logic [5:0] g,
                          input logic [5:0] b, input string req);
    pixIdx = idx;
    @(posedge clk); #1;
    chk(req, 8'(pixRed), 8'(r));
    chk(req, 8'(pixGreen), 8'(g));
    chk(req, 8'(pixBlue), 8'(b));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared while held in reset
    chk("R1", 8'(pixRed), 8'h00);
    chk("R1", 8'(pixBlue), 8'h00);
    rstN = 1'b1;
    hostRead(2'd0, 8'h00, "R1");
    hostRead(2'd2, 8'h00, "R1");
    hostRead(2'd3, 8'hFF, "R1");

    // R5 / R4: fill all entries from 0 with bytes carrying bits 7:6
    for (int i = 0; i < 256; i++) begin
      hostWrite(2'd1, 8'(i));
      hostWrite(2'd1, 8'(i + 1));
      hostWrite(2'd1, 8'(i + 2));
    end
    hostRead(2'd0, 8'h00, "R5");
    pixCheck(8'd200, comp(200, 0), comp(200, 1), comp(200, 2), "R4");

    // R2: load write index
    hostWrite(2'd0, 8'd10);
    hostRead(2'd0, 8'd10, "R2");

    // R3: red and green only held, commit on blue
    hostWrite(2'd1, 8'hFF);
    hostWrite(2'd1, 8'h01);
    pixCheck(8'd10, comp(10, 0), comp(10, 1), comp(10, 2), "R3");
    hostRead(2'd0, 8'd10, "R3");
    hostWrite(2'd1, 8'hEA);
    pixCheck(8'd10, 6'h3F, 6'h01, 6'h2A, "R3");
    hostRead(2'd0, 8'd11, "R3");

    // R6: read-back from index 10, then advance into 11
    hostWrite(2'd2, 8'd10);
    hostRead(2'd1, 8'h3F, "R6");
    hostRead(2'd1, 8'h01, "R6");
    hostRead(2'd1, 8'h2A, "R6");
    hostRead(2'd2, 8'd11, "R6");
    hostRead(2'd1, 8'(comp(11, 0)), "R6");
    // R6: loading the read index restarts at red; wrap 255 -> 0
    hostWrite(2'd2, 8'd255);
    hostRead(2'd1, 8'(comp(255, 0)), "R6");
    hostRead(2'd1, 8'(comp(255, 1)), "R6");
    hostRead(2'd1, 8'(comp(255, 2)), "R6");
    hostRead(2'd2, 8'd0, "R6");
    hostRead(2'd1, 8'(comp(0, 0)), "R6");

    // R7: mask
    hostWrite(2'd3, 8'h0F);
    hostRead(2'd3, 8'h0F, "R7");
    pixCheck(8'h1A, 6'h3F, 6'h01, 6'h2A, "R7");
    hostWrite(2'd3, 8'hFF);
    pixCheck(8'h1A, comp(26, 0), comp(26, 1), comp(26, 2), "R7");

    // R8: one-cycle latency
    pixIdx = 8'd40;
    #2;
    chk("R8", 8'(pixRed), 8'(comp(26, 0)));
    @(posedge clk); #1;
    chk("R8", 8'(pixRed), 8'(comp(40, 0)));

    // R9: same-entry collision
    hostWrite(2'd0, 8'd50);
    hostWrite(2'd1, 8'h01);
    hostWrite(2'd1, 8'h02);
    pixIdx = 8'd50;
    hostWrite(2'd1, 8'h03);
    chk("R9", 8'(pixRed), 8'h01);
    chk("R9", 8'(pixGreen), 8'h02);
    chk("R9", 8'(pixBlue), 8'h03);

    repeat (2) @(posedge clk);
    #1;
    if (expQ.size() != 0) chk("queue", 8'(expQ.size()), 8'h00);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule